// File: doc/BRIEF.md
# DMA Channel Address and Count Updater

This block keeps the current address and the remaining word count for four DMA channels. It advances them after every completed transfer. A transfer on a channel moves its address up or down by the transfer size and takes the same amount off its count. The size is two when the wide transfer mode is on and the channel is marked as a 16-bit channel. In every other case the size is one. A memory-to-memory transfer always involves channels 0 and 1. Both of their addresses move, and only channel 1's count is consumed. Such a transfer is 16-bit when either of the two channels is marked 16-bit.

The block also drives a shared width/latch pin, given as a value plus an output enable. When wide mode is off the pin floats. When wide mode is on, the pin shows the active transfer's width during the first state of a transfer, with 0 meaning 16-bit and 1 meaning 8-bit. In the read half and the write half of a 16-bit memory-to-memory transfer, the pin enables an external latch that holds the upper data byte. A terminal-count pulse marks the transfer that carries a count below zero.

Loading the registers is done through a simple preset port, and the values can be read back through a read port. Arbitration and bus timing belong to neighbouring blocks.

Top module: `dma_xfer_updater`

## Requirements
- R1: With wide mode on and a channel marked 8-bit, one transfer step moves that channel's address by 1 (down when its direction bit is 1, otherwise up) and lowers its count by 1.
- R2: With wide mode on and a channel marked 16-bit, one transfer step moves that channel's address by 2 in its direction and lowers its count by 2.
- R3: With wide mode off, every channel steps by 1 whatever its width bit, and the pin stays at value 0 with its enable low.
- R4: A memory-to-memory step moves the addresses of channels 0 and 1 (each in its own direction), lowers only channel 1's count, and leaves channel 0's count unchanged. The step size is 2 if either channel 0 or channel 1 is marked 16-bit in wide mode, and 1 otherwise.
- R5: When a step takes a count below zero (old count less than the step size), the count wraps modulo 2^16. In the cycle after that step's clock edge, tc_o is high for one cycle and tc_ch gives the channel.
- R6: Addresses wrap modulo 2^16 in both directions.
- R7: dwl_oe follows wide_en, delayed by one clock edge, and is low out of reset.
- R8: With phase = 1 (first state) and wide mode on, the pin value after the edge is 0 for a 16-bit transfer and 1 for an 8-bit transfer.
- R9: With phase = 2 (read half) or phase = 3 (write half) during a memory-to-memory transfer in wide mode, the pin value after the edge is 1 only for a 16-bit transfer and 0 otherwise. phase = 0 is idle and gives 0.
- R10: A load to a channel overrides a step to the same channel in the same cycle, clears any pending count pulse for that channel, and leaves the other channels untouched.
- R11: After reset, all addresses and counts read 0, and tc_o, dwl_out and dwl_oe are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wide_en | input | 1 | Wide transfer mode enable |
| ch_wide | input | NCH | Per-channel width bit, 1 = 16-bit |
| ch_down | input | NCH | Per-channel direction, 1 = decrement |
| ld_en | input | 1 | Preset strobe |
| ld_ch | input | CHW | Channel to preset |
| ld_addr | input | AW | Preset address |
| ld_cnt | input | CW | Preset count |
| xfer_step | input | 1 | A transfer completed this cycle |
| xfer_ch | input | CHW | Active channel (ignored for memory-to-memory) |
| m2m | input | 1 | Current transfer is memory-to-memory |
| phase | input | 2 | 0 idle, 1 first state, 2 read half, 3 write half |
| rd_ch | input | CHW | Channel to read back |
| rd_addr | output | AW | Current address of rd_ch |
| rd_cnt | output | CW | Current count of rd_ch |
| tc_o | output | 1 | Terminal-count pulse |
| tc_ch | output | CHW | Channel that reached terminal count |
| dwl_out | output | 1 | Width/latch pin value |
| dwl_oe | output | 1 | Width/latch pin drive enable |

## Verification
The assertions assume that a load and a step never arrive together on the same channel unless the load is meant to win. They also assume that the phase code and the memory-to-memory flag are held steady for the whole cycle before each edge. The checks on step size only fire when no load is present, so they can compare each count with its value one edge earlier. The stimulus changes inputs only well after a clock edge. Each transfer is issued as one single-cycle step after the preset has settled. The bench sets one width bit at a time, so the expected width of every transfer is known before the step is issued.

// File: rtl/dmau_pkg.sv
// Package: shared types and helpers for the DMA address/count updater.
// Assumes: phase codes are decoded by the width pin driver only.
package dmau_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_FIRST = 2'd1,
        PH_RDH   = 2'd2,
        PH_WRH   = 2'd3
    } phase_e;

    // Step size for a transfer: 2 for effective 16-bit, else 1.
    function automatic logic [1:0] step_size(input logic two);
        return two ? 2'd2 : 2'd1;
    endfunction

endpackage

// File: rtl/dmau_chan.sv
// Module: dmau_chan
// One channel's current address and current count registers.
// Applies a preset or a single step per cycle and raises a one-cycle
// terminal-count flag when the count is taken below zero.
// Assumes: go_addr/go_cnt are single-cycle strobes; ld wins over steps.
module dmau_chan #(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic [AW-1:0] ld_addr,
    input  logic [CW-1:0] ld_cnt,
    input  logic          go_addr,
    input  logic          go_cnt,
    input  logic          two,
    input  logic          down,
    output logic [AW-1:0] addr,
    output logic [CW-1:0] cnt,
    output logic          tc
);
    import dmau_pkg::*;

    logic [AW-1:0] astep;
    logic [CW-1:0] cstep;

    // Widen the shared step size to each register's width.
    always_comb begin
        astep = AW'(step_size(two));
        cstep = CW'(step_size(two));
    end

    // Address register: preset or step up/down, wrapping naturally.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (ld) begin
            addr <= ld_addr;
        end else if (go_addr) begin
            addr <= down ? addr - astep : addr + astep;
        end
    end

    // Count register and terminal-count flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            tc  <= 1'b0;
        end else if (ld) begin
            cnt <= ld_cnt;
            tc  <= 1'b0;
        end else if (go_cnt) begin
            cnt <= cnt - cstep;
            tc  <= (cnt < cstep);
        end else begin
            tc  <= 1'b0;
        end
    end

endmodule

// File: rtl/dmau_width_sel.sv
// Module: dmau_width_sel
// Decides whether the current transfer is effectively 16-bit.
// Memory-to-memory uses channels 0 and 1 and is wide if either is wide.
// Assumes: NCH >= 2.
module dmau_width_sel #(
    parameter int NCH = 4,
    parameter int CHW = 2
) (
    input  logic           wide_en,
    input  logic [NCH-1:0] ch_wide,
    input  logic [CHW-1:0] xfer_ch,
    input  logic           m2m,
    output logic           eff16
);
    // Combine mode, channel width and the memory-to-memory pair rule.
    always_comb begin
        if (!wide_en)
            eff16 = 1'b0;
        else if (m2m)
            eff16 = ch_wide[0] | ch_wide[1];
        else
            eff16 = ch_wide[xfer_ch];
    end

endmodule

// File: rtl/dmau_pin.sv
// Module: dmau_pin
// Registered driver for the shared width/latch pin.
// First state shows width (0 = 16-bit); read/write halves of a wide
// memory-to-memory transfer assert the latch enable. Floats when wide
// mode is off (dwl_oe low).
// Assumes: phase is stable across the cycle before each edge.
module dmau_pin (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wide_en,
    input  logic [1:0] phase,
    input  logic       m2m,
    input  logic       eff16,
    output logic       dwl_out,
    output logic       dwl_oe
);
    import dmau_pkg::*;

    logic   nxt;
    phase_e ph;

    // Decode the phase into the next pin value.
    always_comb begin
        ph  = phase_e'(phase);
        nxt = 1'b0;
        if (wide_en) begin
            case (ph)
                PH_FIRST: nxt = ~eff16;
                PH_RDH,
                PH_WRH:   nxt = m2m & eff16;
                default:  nxt = 1'b0;
            endcase
        end
    end

    // Register pin value and drive enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dwl_out <= 1'b0;
            dwl_oe  <= 1'b0;
        end else begin
            dwl_out <= nxt;
            dwl_oe  <= wide_en;
        end
    end

endmodule

// File: rtl/dma_xfer_updater.sv
// Module: dma_xfer_updater (top)
// Per-transfer updater for NCH DMA channels' address and count, with
// per-channel width and the shared width/latch pin driver.
// Assumes: at most one step per cycle; memory-to-memory uses channels 0/1.
module dma_xfer_updater #(
    parameter int NCH = 4,
    parameter int AW  = 16,
    parameter int CW  = 16,
    localparam int CHW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wide_en,
    input  logic [NCH-1:0] ch_wide,
    input  logic [NCH-1:0] ch_down,
    input  logic           ld_en,
    input  logic [CHW-1:0] ld_ch,
    input  logic [AW-1:0]  ld_addr,
    input  logic [CW-1:0]  ld_cnt,
    input  logic           xfer_step,
    input  logic [CHW-1:0] xfer_ch,
    input  logic           m2m,
    input  logic [1:0]     phase,
    input  logic [CHW-1:0] rd_ch,
    output logic [AW-1:0]  rd_addr,
    output logic [CW-1:0]  rd_cnt,
    output logic           tc_o,
    output logic [CHW-1:0] tc_ch,
    output logic           dwl_out,
    output logic           dwl_oe
);
    logic           eff16;
    logic [AW-1:0]  ch_addr [NCH];
    logic [CW-1:0]  ch_cnt  [NCH];
    logic [NCH-1:0] tc_vec;

    dmau_width_sel #(.NCH(NCH), .CHW(CHW)) u_wsel (
        .wide_en (wide_en),
        .ch_wide (ch_wide),
        .xfer_ch (xfer_ch),
        .m2m     (m2m),
        .eff16   (eff16)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic ld_i, ga_i, gc_i;

        // Steer preset and step strobes to this channel.
        always_comb begin
            ld_i = ld_en && (ld_ch == CHW'(i));
            if (m2m) begin
                ga_i = xfer_step && (i < 2);
                gc_i = xfer_step && (i == 1);
            end else begin
                ga_i = xfer_step && (xfer_ch == CHW'(i));
                gc_i = ga_i;
            end
        end

        dmau_chan #(.AW(AW), .CW(CW)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .ld      (ld_i),
            .ld_addr (ld_addr),
            .ld_cnt  (ld_cnt),
            .go_addr (ga_i),
            .go_cnt  (gc_i),
            .two     (eff16),
            .down    (ch_down[i]),
            .addr    (ch_addr[i]),
            .cnt     (ch_cnt[i]),
            .tc      (tc_vec[i])
        );
    end

    // Encode the terminal-count flags into a pulse and a channel number.
    always_comb begin
        tc_o  = |tc_vec;
        tc_ch = '0;
        for (int k = 0; k < NCH; k++) begin
            if (tc_vec[k]) tc_ch = CHW'(k);
        end
    end

    // Read-back mux.
    always_comb begin
        rd_addr = ch_addr[rd_ch];
        rd_cnt  = ch_cnt[rd_ch];
    end

    dmau_pin u_pin (
        .clk     (clk),
        .rst_n   (rst_n),
        .wide_en (wide_en),
        .phase   (phase),
        .m2m     (m2m),
        .eff16   (eff16),
        .dwl_out (dwl_out),
        .dwl_oe  (dwl_oe)
    );

endmodule

// File: rtl/dma_xfer_updater_chk.sv
// Module: dma_xfer_updater_chk
// Property checker bound to dma_xfer_updater.
module dma_xfer_updater_chk #(
    parameter int NCH = 4,
    parameter int AW  = 16,
    parameter int CW  = 16,
    parameter int CHW = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           wide_en,
    input logic [NCH-1:0] ch_wide,
    input logic           ld_en,
    input logic           xfer_step,
    input logic [CHW-1:0] xfer_ch,
    input logic           m2m,
    input logic [1:0]     phase,
    input logic [CW-1:0]  ch_cnt [NCH],
    input logic           tc_o,
    input logic           dwl_out,
    input logic           dwl_oe
);
    // R7: drive enable follows the mode bit one edge later.
    p_oe_track_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> dwl_oe == $past(wide_en));

    // R3: pin quiet when wide mode off.
    p_off_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wide_en |=> !dwl_out && !dwl_oe);

    // R3: narrow stepping with wide mode off.
    p_off_step_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wide_en && xfer_step && !m2m && !ld_en)
        |=> ch_cnt[$past(xfer_ch)] == CW'($past(ch_cnt[xfer_ch]) - CW'(1)));

    // R4: channel 0 count untouched by memory-to-memory.
    p_m2m_src_cnt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_step && m2m && !ld_en) |=> ch_cnt[0] == $past(ch_cnt[0]));

    // R5: a count pulse only follows a step.
    p_tc_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tc_o |-> $past(xfer_step));

    // R8: first-state width indication.
    p_first_narrow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wide_en && phase == 2'd1 && !m2m && !ch_wide[xfer_ch]) |=> dwl_out);
    p_first_wide_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wide_en && phase == 2'd1 && !m2m && ch_wide[xfer_ch]) |=> !dwl_out);

    // R9: no latch enable for an 8-bit memory-to-memory transfer.
    p_latch_narrow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (m2m && phase[1] && !ch_wide[0] && !ch_wide[1]) |=> !dwl_out);

endmodule

bind dma_xfer_updater dma_xfer_updater_chk #(
    .NCH(NCH), .AW(AW), .CW(CW), .CHW(CHW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wide_en   (wide_en),
    .ch_wide   (ch_wide),
    .ld_en     (ld_en),
    .xfer_step (xfer_step),
    .xfer_ch   (xfer_ch),
    .m2m       (m2m),
    .phase     (phase),
    .ch_cnt    (ch_cnt),
    .tc_o      (tc_o),
    .dwl_out   (dwl_out),
    .dwl_oe    (dwl_oe)
);

// File: tb/sim_dma_xfer_updater.sv
module sim_dma_xfer_updater;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wide_en = 1'b0;
    logic [3:0]  ch_wide = '0;
    logic [3:0]  ch_down = '0;
    logic        ld_en = 1'b0;
    logic [1:0]  ld_ch = '0;
    logic [15:0] ld_addr = '0;
    logic [15:0] ld_cnt = '0;
    logic        xfer_step = 1'b0;
    logic [1:0]  xfer_ch = '0;
    logic        m2m = 1'b0;
    logic [1:0]  phase = '0;
    logic [1:0]  rd_ch = '0;
    logic [15:0] rd_addr, rd_cnt;
    logic        tc_o, dwl_out, dwl_oe;
    logic [1:0]  tc_ch;

    int n_run = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dma_xfer_updater u0 (
        .clk(clk), .rst_n(rst_n), .wide_en(wide_en), .ch_wide(ch_wide),
        .ch_down(ch_down), .ld_en(ld_en), .ld_ch(ld_ch), .ld_addr(ld_addr),
        .ld_cnt(ld_cnt), .xfer_step(xfer_step), .xfer_ch(xfer_ch), .m2m(m2m),
        .phase(phase), .rd_ch(rd_ch), .rd_addr(rd_addr), .rd_cnt(rd_cnt),
        .tc_o(tc_o), .tc_ch(tc_ch), .dwl_out(dwl_out), .dwl_oe(dwl_oe)
    );

    typedef struct packed {
        logic [1:0]  ch;
        logic        wide;
        logic        w;
        logic        dn;
        logic [15:0] a0;
        logic [15:0] c0;
        logic [15:0] ea;
        logic [15:0] ec;
        logic        etc;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{2'd0, 1'b0, 1'b1, 1'b0, 16'h1000, 16'd5,  16'h1001, 16'd4,    1'b0}, // R3
        '{2'd1, 1'b1, 1'b1, 1'b0, 16'h2000, 16'd10, 16'h2002, 16'd8,    1'b0}, // R2
        '{2'd2, 1'b1, 1'b1, 1'b1, 16'h3000, 16'd3,  16'h2FFE, 16'd1,    1'b0}, // R2
        '{2'd3, 1'b1, 1'b0, 1'b1, 16'h0400, 16'd7,  16'h03FF, 16'd6,    1'b0}, // R1
        '{2'd3, 1'b1, 1'b1, 1'b0, 16'hFFFF, 16'd2,  16'h0001, 16'd0,    1'b0}, // R6
        '{2'd2, 1'b0, 1'b0, 1'b1, 16'h0000, 16'd0,  16'hFFFF, 16'hFFFF, 1'b1}, // R5 R6
        '{2'd1, 1'b1, 1'b1, 1'b0, 16'h0010, 16'd1,  16'h0012, 16'hFFFF, 1'b1}, // R5
        '{2'd0, 1'b1, 1'b0, 1'b0, 16'hFFFF, 16'h100, 16'h0000, 16'h00FF, 1'b0} // R6
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    // Advance one edge and move to a point away from it.
    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic preset(input logic [1:0] c, input logic [15:0] a, input logic [15:0] n);
        ld_en = 1'b1; ld_ch = c; ld_addr = a; ld_cnt = n;
        tick();
        ld_en = 1'b0;
    endtask

    task automatic step(input logic [1:0] c, input logic mm);
        xfer_step = 1'b1; xfer_ch = c; m2m = mm;
        tick();
        xfer_step = 1'b0; m2m = 1'b0;
    endtask

    initial begin
        repeat (3) tick();
        // R11 reset state
        for (int c = 0; c < 4; c++) begin
            rd_ch = 2'(c); #1;
            chk("R11 addr", 32'(rd_addr), 32'h0);
            chk("R11 cnt", 32'(rd_cnt), 32'h0);
        end
        chk("R11 tc", 32'(tc_o), 32'h0);
        chk("R11 dwl_out", 32'(dwl_out), 32'h0);
        chk("R11 dwl_oe", 32'(dwl_oe), 32'h0);
        rst_n = 1'b1;
        tick();

        // Vector table: R1 R2 R3 R5 R6
        for (int v = 0; v < 8; v++) begin
            wide_en = VECS[v].wide;
            ch_wide = 4'(VECS[v].w) << VECS[v].ch;
            ch_down = 4'(VECS[v].dn) << VECS[v].ch;
            preset(VECS[v].ch, VECS[v].a0, VECS[v].c0);
            step(VECS[v].ch, 1'b0);
            chk($sformatf("R5 tc vec%0d", v), 32'(tc_o), 32'(VECS[v].etc));
            if (VECS[v].etc) chk("R5 tc_ch", 32'(tc_ch), 32'(VECS[v].ch));
            rd_ch = VECS[v].ch; #1;
            chk($sformatf("R1/R2 addr vec%0d", v), 32'(rd_addr), 32'(VECS[v].ea));
            chk($sformatf("R1/R2 cnt vec%0d", v), 32'(rd_cnt), 32'(VECS[v].ec));
            tick();
            chk("R5 tc one cycle", 32'(tc_o), 32'h0);
        end

        // R4 memory-to-memory, ch1 wide -> step 2
        wide_en = 1'b1; ch_wide = 4'b0010; ch_down = 4'b0000;
        preset(2'd0, 16'h0100, 16'd9);
        preset(2'd1, 16'h0200, 16'd4);
        step(2'd3, 1'b1);
        rd_ch = 2'd0; #1;
        chk("R4 ch0 addr", 32'(rd_addr), 32'h0102);
        chk("R4 ch0 cnt", 32'(rd_cnt), 32'd9);
        rd_ch = 2'd1; #1;
        chk("R4 ch1 addr", 32'(rd_addr), 32'h0202);
        chk("R4 ch1 cnt", 32'(rd_cnt), 32'd2);
        // R4 both narrow -> step 1
        ch_wide = 4'b0000;
        step(2'd2, 1'b1);
        rd_ch = 2'd0; #1;
        chk("R4 narrow ch0 addr", 32'(rd_addr), 32'h0103);
        rd_ch = 2'd1; #1;
        chk("R4 narrow ch1 addr", 32'(rd_addr), 32'h0203);
        chk("R4 narrow ch1 cnt", 32'(rd_cnt), 32'd1);

        // R8 first-state width indication
        wide_en = 1'b1; ch_wide = 4'b0100; xfer_ch = 2'd2; phase = 2'd1;
        tick();
        chk("R8 wide ch out", 32'(dwl_out), 32'h0);
        chk("R7 oe on", 32'(dwl_oe), 32'h1);
        ch_wide = 4'b0000;
        tick();
        chk("R8 narrow ch out", 32'(dwl_out), 32'h1);
        // R9 latch phases
        m2m = 1'b1; ch_wide = 4'b0001; phase = 2'd2;
        tick();
        chk("R9 read half wide", 32'(dwl_out), 32'h1);
        phase = 2'd3;
        tick();
        chk("R9 write half wide", 32'(dwl_out), 32'h1);
        ch_wide = 4'b0000; phase = 2'd2;
        tick();
        chk("R9 read half narrow", 32'(dwl_out), 32'h0);
        ch_wide = 4'b0001; phase = 2'd0;
        tick();
        chk("R9 idle", 32'(dwl_out), 32'h0);
        m2m = 1'b0;
        // R3/R7 wide off floats the pin
        wide_en = 1'b0; phase = 2'd1;
        tick();
        chk("R7 oe off", 32'(dwl_oe), 32'h0);
        chk("R3 out off", 32'(dwl_out), 32'h0);
        phase = 2'd0;

        // R10 load beats a same-cycle step
        wide_en = 1'b1;
        ld_en = 1'b1; ld_ch = 2'd3; ld_addr = 16'h5555; ld_cnt = 16'h0010;
        xfer_step = 1'b1; xfer_ch = 2'd3;
        tick();
        ld_en = 1'b0; xfer_step = 1'b0;
        rd_ch = 2'd3; #1;
        chk("R10 addr", 32'(rd_addr), 32'h5555);
        chk("R10 cnt", 32'(rd_cnt), 32'h0010);
        chk("R10 tc", 32'(tc_o), 32'h0);
        rd_ch = 2'd0; #1;
        chk("R10 other ch", 32'(rd_addr), 32'h0103);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
            $finish;
        end
    end

endmodule